// File: doc/BRIEF.md
# Interrupt Status Unit for an I2C Master

This block gathers the twelve event lines of an I2C master controller into one interrupt. Single-cycle event pulses are held in a raw status register until software clears them. Two sources are level conditions: receive-full and transmit-empty. Their raw bits track the input every cycle. A mask register gates the raw bits into a masked status. The OR of the masked bits, registered once, drives the interrupt line.

Software clears events through read side effects. Each source has its own clear address, and reading it clears only that bit. An event that arrives after software read the status therefore cannot be lost by a clear aimed at a different bit. A combined clear address clears every pulse-type bit in one read.

A separate abort-cause register accumulates the reason bits offered with each transmit-abort event. It empties together with the abort flag, so software must read it before it clears the abort.

Top module: `intr_status_unit`

## Requirements
- R1: After reset the raw status and the abort-cause register read 0, the mask register (word address 0x02) reads 0x254, and `irq` is 0.
- R2: A one-cycle high on `evt_in[i]` of a pulse-type source sets raw bit i, which stays set until it is cleared. Bit order: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detect, 10 start detect, 11 general call. Raw status is read at word address 0x00.
- R3: Masked status, read at address 0x01, equals raw status AND the mask. The mask is written at address 0x02 using `wdata[11:0]`.
- R4: A read of address 0x10+i clears raw bit i only and returns 0.
- R5: A read of the combined clear address 0x04 clears all pulse-type raw bits and returns 0.
- R6: If an event on a source coincides with a clear read that covers that source, the event wins and the bit stays set.
- R7: Raw bits 2 (rx full) and 4 (tx empty) equal `evt_in` of the previous cycle, and no clear read changes them.
- R8: In a cycle with `evt_in[6]` high, the bits of `abort_cause` are ORed into the abort-cause register (address 0x03). Only bits 0-5, 7 and 9-12 are stored; bits 6 and 8 always read 0. `abort_cause` is ignored when `evt_in[6]` is low.
- R9: A read of 0x16 or of 0x04 clears the abort-cause register. A read of 0x03 made before the clear returns the accumulated causes.
- R10: `irq` is 1 exactly one cycle after the masked status is non-zero, and 0 one cycle after it is zero.
- R11: Writes to any address other than 0x02 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 12 | Event pulses and the two level conditions, one per source |
| abort_cause | input | 13 | Cause bits that go with a transmit-abort event |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
An event or a clear read takes effect at the clock edge that samples it. Read data follows one edge after the read strobe. `irq` lags the raw and mask registers by one more edge, so it changes two edges after an event pulse is driven. The bench drives on falling edges and samples on the following falling edges. It checks `irq` both at the falling edge where it must still be low and at the next one, where it must have risen. For the coincidence case, the clear strobe and the event pulse are driven in the same falling-edge window, and the raw status is read back afterwards.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NSRC_DEF   = 12;
  localparam int ABRT_W_DEF = 13;
  localparam int DATA_W_DEF = 16;
  localparam int ADDR_W_DEF = 5;

  // bit positions that other logic decodes
  localparam int SRC_RX_FULL  = 2;
  localparam int SRC_TX_EMPTY = 4;
  localparam int SRC_TX_ABRT  = 6;
  localparam int SRC_STOP     = 9;

  // word addresses
  localparam int ADR_RAW     = 5'h00;
  localparam int ADR_MASKED  = 5'h01;
  localparam int ADR_MASK    = 5'h02;
  localparam int ADR_ABORT   = 5'h03;
  localparam int ADR_CLR_ALL = 5'h04;
  localparam int ADR_CLR_SRC = 5'h10;

  function automatic logic [NSRC_DEF-1:0] level_sources();
    logic [NSRC_DEF-1:0] m;
    m = '0;
    m[SRC_RX_FULL]  = 1'b1;
    m[SRC_TX_EMPTY] = 1'b1;
    return m;
  endfunction

  function automatic logic [NSRC_DEF-1:0] reset_mask();
    logic [NSRC_DEF-1:0] m;
    m = '0;
    m[SRC_RX_FULL]  = 1'b1;
    m[SRC_TX_EMPTY] = 1'b1;
    m[SRC_TX_ABRT]  = 1'b1;
    m[SRC_STOP]     = 1'b1;
    return m;
  endfunction

  // stored abort-cause bits: 0..5, 7, 9..12
  function automatic logic [ABRT_W_DEF-1:0] abort_keep();
    logic [ABRT_W_DEF-1:0] m;
    m = '1;
    m[6] = 1'b0;
    m[8] = 1'b0;
    return m;
  endfunction

  function automatic logic intr_reduce(input logic [NSRC_DEF-1:0] raw,
                                       input logic [NSRC_DEF-1:0] mask);
    return |(raw & mask);
  endfunction
endpackage

// File: rtl/intr_raw_bank.sv
module intr_raw_bank #(
  parameter int NSRC = 12,
  parameter logic [NSRC-1:0] LVL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_in,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] raw_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LVL_MASK[i]) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q[i] <= 1'b0;
        else        raw_q[i] <= evt_in[i];
      end
    end else begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q[i] <= 1'b0;
        else        raw_q[i] <= evt_in[i] | (raw_q[i] & ~clr_vec[i]);
      end
    end
  end
endmodule

// File: rtl/intr_abort_src.sv
module intr_abort_src #(
  parameter int ABRT_W = 13,
  parameter logic [ABRT_W-1:0] KEEP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ABRT_W-1:0] cause_in,
  input  logic              clr,
  output logic [ABRT_W-1:0] abort_q
);
  logic [ABRT_W-1:0] kept;
  logic [ABRT_W-1:0] fresh;

  always_comb begin
    kept  = clr ? '0 : abort_q;
    fresh = capture ? (cause_in & KEEP) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= '0;
    else        abort_q <= kept | fresh;
  end
endmodule

// File: rtl/intr_reg_port.sv
module intr_reg_port #(
  parameter int NSRC   = 12,
  parameter int ABRT_W = 13,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter logic [NSRC-1:0] MASK_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   raw_q,
  input  logic [NSRC-1:0]   masked_w,
  input  logic [ABRT_W-1:0] abort_q,
  output logic [NSRC-1:0]   mask_q,
  output logic [NSRC-1:0]   clr_vec,
  output logic [DATA_W-1:0] rdata
);
  import intr_pkg::*;

  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(ADR_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(ADR_MASKED);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_ABORT  = ADDR_W'(ADR_ABORT);
  localparam logic [ADDR_W-1:0] A_CLRALL = ADDR_W'(ADR_CLR_ALL);

  logic clr_all;
  assign clr_all = rd_en && (addr == A_CLRALL);

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    localparam logic [ADDR_W-1:0] A_CLR_I = ADDR_W'(ADR_CLR_SRC + i);
    assign clr_vec[i] = clr_all || (rd_en && (addr == A_CLR_I));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_RST;
    else if (wr_en && (addr == A_MASK)) mask_q <= wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      if (addr == A_RAW)         rdata <= DATA_W'(raw_q);
      else if (addr == A_MASKED) rdata <= DATA_W'(masked_w);
      else if (addr == A_MASK)   rdata <= DATA_W'(mask_q);
      else if (addr == A_ABORT)  rdata <= DATA_W'(abort_q);
      else                       rdata <= '0;
    end
  end
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit #(
  parameter int NSRC   = intr_pkg::NSRC_DEF,
  parameter int ABRT_W = intr_pkg::ABRT_W_DEF,
  parameter int DATA_W = intr_pkg::DATA_W_DEF,
  parameter int ADDR_W = intr_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_in,
  input  logic [ABRT_W-1:0] abort_cause,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import intr_pkg::*;

  localparam logic [NSRC-1:0]   LVL_MASK = NSRC'(level_sources());
  localparam logic [NSRC-1:0]   MASK_RST = NSRC'(reset_mask());
  localparam logic [ABRT_W-1:0] ABRT_KEEP = ABRT_W'(abort_keep());

  // named internal events
  logic [NSRC-1:0]   raw_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   masked_w;
  logic [NSRC-1:0]   clr_vec;
  logic [ABRT_W-1:0] abort_q;
  logic              abort_clr;
  logic              abort_evt;

  assign masked_w  = raw_q & mask_q;
  assign abort_clr = clr_vec[SRC_TX_ABRT];
  assign abort_evt = evt_in[SRC_TX_ABRT];

  intr_raw_bank #(.NSRC(NSRC), .LVL_MASK(LVL_MASK)) u_raw (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_vec(clr_vec), .raw_q(raw_q)
  );

  intr_abort_src #(.ABRT_W(ABRT_W), .KEEP(ABRT_KEEP)) u_abort (
    .clk(clk), .rst_n(rst_n), .capture(abort_evt), .cause_in(abort_cause),
    .clr(abort_clr), .abort_q(abort_q)
  );

  intr_reg_port #(
    .NSRC(NSRC), .ABRT_W(ABRT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK_RST(MASK_RST)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .raw_q(raw_q), .masked_w(masked_w), .abort_q(abort_q),
    .mask_q(mask_q), .clr_vec(clr_vec), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked_w;
  end
endmodule

// File: rtl/intr_status_chk.sv
module intr_status_chk #(
  parameter int NSRC   = 12,
  parameter int ABRT_W = 13,
  parameter logic [NSRC-1:0]   LVL_MASK = '0,
  parameter logic [ABRT_W-1:0] KEEP = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_in,
  input logic [NSRC-1:0]   raw_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   clr_vec,
  input logic [ABRT_W-1:0] abort_q,
  input logic [ABRT_W-1:0] abort_cause,
  input logic              abort_clr,
  input logic              abort_evt,
  input logic              irq
);
  localparam logic [NSRC-1:0] EDGE = ~LVL_MASK;

  AST_CLR_ONLY_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_q) & ~raw_q) & EDGE & ~$past(clr_vec)) == '0)); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(evt_in) & EDGE) == ($past(evt_in) & EDGE))); // R6

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & LVL_MASK) == ($past(evt_in) & LVL_MASK))); // R7

  AST_ABORT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> ((abort_q & $past(abort_cause) & KEEP) == ($past(abort_cause) & KEEP))); // R8

  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_clr && !abort_evt) |=> (abort_q == '0)); // R9

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & mask_q) != '0) |=> irq); // R10

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & mask_q) == '0) |=> !irq); // R10
endmodule

bind intr_status_unit intr_status_chk #(
  .NSRC(NSRC), .ABRT_W(ABRT_W), .LVL_MASK(LVL_MASK), .KEEP(ABRT_KEEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .raw_q(raw_q), .mask_q(mask_q),
  .clr_vec(clr_vec), .abort_q(abort_q), .abort_cause(abort_cause),
  .abort_clr(abort_clr), .abort_evt(abort_evt), .irq(irq)
);

// File: tb/intr_status_unit_bench.sv
module intr_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ev = '0;
  logic [11:0] lvl = '0;
  logic [11:0] evt_in;
  logic [12:0] cz = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [11:0] EDGE_BITS = 12'hFEB;
  localparam logic [11:0] MASK_DEF  = 12'h254;

  assign evt_in = ev | lvl;

  always #10 clk = ~clk;

  intr_status_unit u_intr_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .abort_cause(cz),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] bits, input logic [12:0] cause);
    @(negedge clk); ev = bits; cz = cause;
    @(negedge clk); ev = '0; cz = '0;
  endtask

  initial begin
    logic [15:0] d;
    logic [11:0] exp_raw;
    logic [12:0] exp_ab;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    rd(5'h00, d); chk("R1 raw", d, 16'h0);
    rd(5'h02, d); chk("R1 mask", d, {4'h0, MASK_DEF});
    rd(5'h03, d); chk("R1 abort", d, 16'h0);

    // R2/R3/R4/R10 single-source sweep
    for (int i = 0; i < 12; i++) begin
      if (!EDGE_BITS[i]) continue;
      pulse(12'(1 << i), '0);
      chk("R10 irq not yet", {15'd0, irq}, 16'h0);
      @(negedge clk);
      chk("R10 irq", {15'd0, irq}, {15'd0, MASK_DEF[i]});
      rd(5'h00, d); chk("R2 raw", d, 16'(1 << i));
      rd(5'h01, d); chk("R3 masked", d, 16'(1 << i) & {4'h0, MASK_DEF});
      rd(5'(16 + i), d); chk("R4 clear returns 0", d, 16'h0);
      rd(5'h00, d); chk("R4 raw cleared", d, 16'h0);
    end

    // R4 clear one of many
    pulse(EDGE_BITS, '0);
    exp_raw = EDGE_BITS;
    for (int j = 0; j < 12; j++) begin
      if (!EDGE_BITS[j]) continue;
      rd(5'(16 + j), d);
      exp_raw[j] = 1'b0;
      rd(5'h00, d); chk("R4 only own bit", d, {4'h0, exp_raw});
    end

    // R5 combined clear
    pulse(EDGE_BITS, '0);
    rd(5'h04, d); chk("R5 clear-all returns 0", d, 16'h0);
    rd(5'h00, d); chk("R5 raw after clear-all", d, 16'h0);

    // R6 event coincides with clear
    @(negedge clk); ev = 12'h200; rd_en = 1'b1; addr = 5'h19;
    @(negedge clk); ev = '0; rd_en = 1'b0;
    rd(5'h00, d); chk("R6 own clear", d, 16'h200);
    @(negedge clk); ev = 12'h208; rd_en = 1'b1; addr = 5'h04;
    @(negedge clk); ev = '0; rd_en = 1'b0;
    rd(5'h00, d); chk("R6 clear-all", d, 16'h208);
    rd(5'h04, d);

    // R7 level sources
    @(negedge clk); lvl = 12'h014;
    @(negedge clk);
    rd(5'h00, d); chk("R7 level set", d, 16'h014);
    rd(5'h12, d); rd(5'h14, d); rd(5'h04, d);
    rd(5'h00, d); chk("R7 clears ignored", d, 16'h014);
    @(negedge clk); lvl = 12'h004;
    @(negedge clk);
    rd(5'h00, d); chk("R7 level follows", d, 16'h004);
    lvl = '0;

    // R3/R10 mask sweep with all sources active
    pulse(EDGE_BITS, '0);
    lvl = 12'h014;
    for (int k = 0; k < 12; k++) begin
      wr(5'h02, 16'(1 << k));
      @(negedge clk);
      chk("R10 irq single mask bit", {15'd0, irq}, 16'h1);
      rd(5'h01, d); chk("R3 masked sweep", d, 16'(1 << k));
    end
    wr(5'h02, 16'h0);
    @(negedge clk);
    chk("R10 irq masked off", {15'd0, irq}, 16'h0);
    rd(5'h01, d); chk("R3 masked zero", d, 16'h0);
    lvl = '0;
    rd(5'h04, d);
    wr(5'h02, 16'h0A5A);
    pulse(12'h0C3, '0);
    rd(5'h01, d); chk("R3 masked pattern", d, 16'h0C3 & 16'h0A5A);
    rd(5'h02, d); chk("R3 mask readback", d, 16'h0A5A);
    rd(5'h04, d);
    wr(5'h02, {4'h0, MASK_DEF});

    // R8/R9 abort cause
    @(negedge clk); cz = 13'h0001;
    @(negedge clk); cz = '0;
    rd(5'h03, d); chk("R8 cause without event", d, 16'h0);
    pulse(12'h040, 13'h0009);
    rd(5'h03, d); chk("R8 capture", d, 16'h0009);
    pulse(12'h040, 13'h1000);
    exp_ab = 13'h1009;
    rd(5'h03, d); chk("R8 accumulate", d, {3'h0, exp_ab});
    pulse(12'h040, 13'h0140);
    rd(5'h03, d); chk("R8 unstored bits", d, {3'h0, exp_ab});
    rd(5'h00, d); chk("R8 abort flag", d, 16'h040);
    rd(5'h16, d);
    rd(5'h03, d); chk("R9 own clear", d, 16'h0);
    rd(5'h00, d); chk("R9 flag cleared", d, 16'h0);
    pulse(12'h040, 13'h0800);
    rd(5'h04, d);
    rd(5'h03, d); chk("R9 clear-all", d, 16'h0);

    // R11 writes elsewhere ignored
    pulse(12'h240, 13'h0002);
    wr(5'h00, 16'h0000); wr(5'h03, 16'h0000); wr(5'h19, 16'hFFFF); wr(5'h04, 16'hFFFF);
    rd(5'h00, d); chk("R11 raw kept", d, 16'h240);
    rd(5'h03, d); chk("R11 abort kept", d, 16'h0002);
    rd(5'h02, d); chk("R11 mask kept", d, {4'h0, MASK_DEF});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule